// File: doc/BRIEF.md
# SMI Status Aggregation and Routing

This block keeps a 16-bit status word that collects power-management and system-management events and turns them into two level outputs: a system-management interrupt request and a wake request. Event strobes arrive from neighbouring logic: an ECC error line, a firmware write-enable configuration bit, GPIO lines with their SMI routing, a software SMI timer expiry, a one-minute timer expiry, a write to the power-management control port, and a firmware-release request. Summary vectors from other status registers, enable bits and the current power state are also inputs.

Seven of the status bits are sticky. Hardware sets them, and software clears them by writing 1 to their position. Three bits are not stored: they show the live OR of other registers. The SMI request stays high while any pending sticky bit has its SMI path enabled. The GPIO event bit is routed to SMI, to wake or to both, depending on the power state. Reads are combinational from the stored bits and the live inputs. The internal reset is released two clocks after the external reset goes high.

Top module: `smi_status_agg`

## Requirements
- R1: After reset `reg_rdata`, `smi_req` and `wake_req` are all 0. Bits 15:11 and bit 2 of `reg_rdata` always read 0, even after writes of all ones.
- R2: When `ecc_serr_en` is 0, one clock of `ecc_irq` high sets bit 10.
- R3: When `ecc_serr_en` is 1, `ecc_irq` must be high on two consecutive clocks before bit 10 sets. A single-clock pulse leaves the bit at 0.
- R4: A set bit 10 drives `smi_req` only while `ecc_smi_en` is 1.
- R5: A rising edge of `fw_wr_en_cfg` sets bit 9. Holding the input high does not set the bit again after it is cleared. Bit 9 always drives `smi_req`.
- R6: Bit 8 sets when any GPIO has both `gpio_lvl` and `gpio_smi_route` high. With `ext_evt_en` at 1 the routing depends on `pwr_state`:
  - Codes 0, 1 and 2 (S0/C0, S0/C1, S0/C2) raise SMI only.
  - Code 3 (S1) raises both SMI and wake.
  - Codes 4, 5 and 6 (S3, S4, S5) raise wake only.
  - Code 7 raises neither.
  - With `ext_evt_en` at 0, bit 8 raises neither.
- R7: `swt_expire` sets bit 7, which does not drive `smi_req`. `minute_expire` sets bit 6, which always drives `smi_req`.
- R8: Bit 5 reads as the OR of `gp_sts_vec`. Bit 4 reads as the OR of `pm1_sts_vec`. Bit 1 reads as the OR of `usb_sts & usb_en`. All three follow their inputs in the same cycle and ignore writes.
- R9: `pmc_wr` sets bit 3, which drives `smi_req` only while `pmc_en` is 1. `rel_req_wr` sets bit 0 only while `fw_rel_en` is 1, and bit 0 always drives `smi_req`.
- R10: A write with a data bit at 1 clears that sticky bit on the next edge. A data bit at 0 leaves it unchanged.
- R11: If a set event and a clearing write hit the same bit in the same clock, the bit ends up set.
- R12: `smi_req` and `wake_req` are levels. They stay high for as long as the causing status bit is pending, with no further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_irq | input | 1 | ECC error interrupt level |
| ecc_serr_en | input | 1 | Requires the ECC level to be held two clocks |
| ecc_smi_en | input | 1 | Lets bit 10 request SMI |
| fw_wr_en_cfg | input | 1 | Firmware write-enable configuration bit |
| gpio_lvl | input | GPIO_W (8) | GPIO input levels |
| gpio_smi_route | input | GPIO_W (8) | GPIOs routed to the SMI event |
| ext_evt_en | input | 1 | Enables routing of bit 8 |
| pwr_state | input | 3 | Power state code (see R6) |
| swt_expire | input | 1 | Software SMI timer expiry pulse |
| minute_expire | input | 1 | One-minute timer expiry pulse |
| pmc_wr | input | 1 | Power-management control port write pulse |
| pmc_en | input | 1 | Lets bit 3 request SMI |
| rel_req_wr | input | 1 | Software write of 1 to the firmware-release bit |
| fw_rel_en | input | 1 | Qualifies the firmware-release request |
| gp_sts_vec | input | GP_W (8) | General-purpose status vector |
| pm1_sts_vec | input | PM1_W (8) | PM1 status vector |
| usb_sts | input | USB_W (4) | USB legacy SMI status bits |
| usb_en | input | USB_W (4) | USB legacy enable bits |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data, 1 clears |
| reg_rdata | output | 16 | Status word |
| smi_req | output | 1 | SMI request level |
| wake_req | output | 1 | Wake request level |

## Verification
- **Sticky bits:** an event sampled at a rising edge shows in `reg_rdata`, `smi_req` and `wake_req` right after that edge. The bench therefore samples a quarter period after each edge, with the inputs still held from the previous falling edge.
- **Qualified ECC:** the bit appears only after the second consecutive edge, so the reference model keeps the previous ECC level.
- **Live bits:** they follow their inputs within the same cycle.
- **Scoreboard:** every stimulus cycle pushes one expected entry. Each entry is compared at the edge that follows its push.
- **Reset:** no events are driven until the two-clock reset release has passed.

// File: rtl/smi_agg_pkg.sv
`timescale 1ns/1ps
package smi_agg_pkg;
  localparam int STS_W = 16;

  // bit positions inside the status word
  localparam int B_REL  = 0;
  localparam int B_USB  = 1;
  localparam int B_PMC  = 3;
  localparam int B_PM1  = 4;
  localparam int B_GP   = 5;
  localparam int B_MIN  = 6;
  localparam int B_SWT  = 7;
  localparam int B_EXT  = 8;
  localparam int B_FWWE = 9;
  localparam int B_ECC  = 10;

  // sticky (stored) bits and live (summary) bits
  localparam logic [STS_W-1:0] STORE_MASK = 16'h07C9;
  localparam logic [STS_W-1:0] LIVE_MASK  = 16'h0032;

  typedef enum logic [2:0] {
    PS_S0C0 = 3'd0,
    PS_S0C1 = 3'd1,
    PS_S0C2 = 3'd2,
    PS_S1   = 3'd3,
    PS_S3   = 3'd4,
    PS_S4   = 3'd5,
    PS_S5   = 3'd6,
    PS_RSVD = 3'd7
  } pwr_state_e;

  function automatic logic ext_to_smi(input pwr_state_e s);
    return (s == PS_S0C0) || (s == PS_S0C1) || (s == PS_S0C2) || (s == PS_S1);
  endfunction

  function automatic logic ext_to_wake(input pwr_state_e s);
    return (s == PS_S1) || (s == PS_S3) || (s == PS_S4) || (s == PS_S5);
  endfunction
endpackage

// File: rtl/smi_rst_sync.sv
`timescale 1ns/1ps
module smi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_r;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_r[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_r <= '0;
    end else begin
      sync_r <= sync_nxt;
    end
  end

  assign rst_n_o = sync_r[STAGES-1];
endmodule

// File: rtl/smi_ecc_qual.sv
`timescale 1ns/1ps
module smi_ecc_qual #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic serr_en_i,
  output logic hit_o
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HOLD_CYC - 1);

  logic [CW-1:0] run_r;
  logic [CW-1:0] run_nxt;
  logic          run_en;

  always_comb begin
    run_nxt = run_r;
    if (!irq_i) begin
      run_nxt = '0;
    end else if (run_r != CMAX) begin
      run_nxt = run_r + 1'b1;
    end
    run_en = (run_nxt != run_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_r <= '0;
    end else if (run_en) begin
      run_r <= run_nxt;
    end
  end

  // unqualified mode: any high clock; qualified mode: held past the window
  assign hit_o = irq_i & (~serr_en_i | (run_r == CMAX));
endmodule

// File: rtl/smi_rise_det.sv
`timescale 1ns/1ps
module smi_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_r;
  logic prev_en;

  always_comb begin
    prev_en = (lvl_i != prev_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_r <= 1'b0;
    end else if (prev_en) begin
      prev_r <= lvl_i;
    end
  end

  assign rise_o = lvl_i & ~prev_r;
endmodule

// File: rtl/smi_sticky_bank.sv
`timescale 1ns/1ps
module smi_sticky_bank #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      if (MASK[g]) begin : g_store
        // a set in the same cycle as a clear keeps the bit
        assign q_nxt[g] = set_i[g] | (q_r[g] & ~clr_i[g]);
      end else begin : g_none
        assign q_nxt[g] = 1'b0;
      end
    end
  endgenerate

  assign upd = |((set_i | clr_i) & MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd) begin
      q_r <= q_nxt;
    end
  end

  assign q_o = q_r & MASK;
endmodule

// File: rtl/smi_req_route.sv
`timescale 1ns/1ps
module smi_req_route
  import smi_agg_pkg::*;
(
  input  logic [STS_W-1:0] sts_i,
  input  logic             ecc_smi_en_i,
  input  logic             pmc_en_i,
  input  logic             ext_en_i,
  input  pwr_state_e       pstate_i,
  output logic             smi_o,
  output logic             wake_o
);
  logic ext_live;
  logic ecc_path;
  logic pmc_path;
  logic ext_smi_path;
  logic fixed_path;

  always_comb begin
    ext_live     = sts_i[B_EXT] & ext_en_i;
    ecc_path     = sts_i[B_ECC] & ecc_smi_en_i;
    pmc_path     = sts_i[B_PMC] & pmc_en_i;
    ext_smi_path = ext_live & ext_to_smi(pstate_i);
    fixed_path   = sts_i[B_FWWE] | sts_i[B_MIN] | sts_i[B_REL];
    smi_o        = ecc_path | pmc_path | ext_smi_path | fixed_path;
    wake_o       = ext_live & ext_to_wake(pstate_i);
  end
endmodule

// File: rtl/smi_status_agg.sv
`timescale 1ns/1ps
module smi_status_agg
  import smi_agg_pkg::*;
#(
  parameter int GPIO_W   = 8,
  parameter int GP_W     = 8,
  parameter int PM1_W    = 8,
  parameter int USB_W    = 4,
  parameter int ECC_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_irq,
  input  logic              ecc_serr_en,
  input  logic              ecc_smi_en,
  input  logic              fw_wr_en_cfg,
  input  logic [GPIO_W-1:0] gpio_lvl,
  input  logic [GPIO_W-1:0] gpio_smi_route,
  input  logic              ext_evt_en,
  input  logic [2:0]        pwr_state,
  input  logic              swt_expire,
  input  logic              minute_expire,
  input  logic              pmc_wr,
  input  logic              pmc_en,
  input  logic              rel_req_wr,
  input  logic              fw_rel_en,
  input  logic [GP_W-1:0]   gp_sts_vec,
  input  logic [PM1_W-1:0]  pm1_sts_vec,
  input  logic [USB_W-1:0]  usb_sts,
  input  logic [USB_W-1:0]  usb_en,
  input  logic              reg_wr,
  input  logic [STS_W-1:0]  reg_wdata,
  output logic [STS_W-1:0]  reg_rdata,
  output logic              smi_req,
  output logic              wake_req
);
  logic             rst_sync_n;
  logic             ecc_hit;
  logic             fwwe_rise;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] live_vec;
  pwr_state_e       pstate;

  smi_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  smi_ecc_qual #(.HOLD_CYC(ECC_HOLD)) i_ecc_qual (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .irq_i     (ecc_irq),
    .serr_en_i (ecc_serr_en),
    .hit_o     (ecc_hit)
  );

  smi_rise_det i_fwwe_rise (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (fw_wr_en_cfg),
    .rise_o (fwwe_rise)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_ECC]  = ecc_hit;
    set_vec[B_FWWE] = fwwe_rise;
    set_vec[B_EXT]  = |(gpio_lvl & gpio_smi_route);
    set_vec[B_SWT]  = swt_expire;
    set_vec[B_MIN]  = minute_expire;
    set_vec[B_PMC]  = pmc_wr;
    set_vec[B_REL]  = rel_req_wr & fw_rel_en;
    clr_vec         = reg_wr ? (reg_wdata & STORE_MASK) : '0;
  end

  smi_sticky_bank #(.W(STS_W), .MASK(STORE_MASK)) i_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (sts_q)
  );

  always_comb begin
    live_vec        = '0;
    live_vec[B_GP]  = |gp_sts_vec;
    live_vec[B_PM1] = |pm1_sts_vec;
    live_vec[B_USB] = |(usb_sts & usb_en);
    reg_rdata       = sts_q | (live_vec & LIVE_MASK);
    pstate          = pwr_state_e'(pwr_state);
  end

  smi_req_route i_route (
    .sts_i        (sts_q),
    .ecc_smi_en_i (ecc_smi_en),
    .pmc_en_i     (pmc_en),
    .ext_en_i     (ext_evt_en),
    .pstate_i     (pstate),
    .smi_o        (smi_req),
    .wake_o       (wake_req)
  );
endmodule

// File: rtl/smi_status_agg_chk.sv
`timescale 1ns/1ps
module smi_status_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ecc_irq,
  input logic        ecc_serr_en,
  input logic        swt_expire,
  input logic        minute_expire,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic [2:0]  pwr_state,
  input logic        ext_evt_en,
  input logic        smi_req,
  input logic        wake_req
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:11] == 5'd0) && !reg_rdata[2]) else $error("reserved bits set"); // R1

  AST_ECC_SHORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_serr_en && ecc_irq && !$past(ecc_irq) && !reg_rdata[10]) |=> !reg_rdata[10]) else $error("short ecc pulse accepted"); // R3

  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (reg_rdata[8] && ext_evt_en && (pwr_state inside {3'd3, 3'd4, 3'd5, 3'd6}))) else $error("wake without cause"); // R6

  AST_DEEP_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state inside {3'd4, 3'd5, 3'd6}) && ((reg_rdata & 16'h0649) == 16'h0000)) |-> !smi_req) else $error("smi in deep state"); // R6

  AST_MINUTE_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |-> smi_req) else $error("minute status without smi"); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[6] && !minute_expire) |=> !reg_rdata[6]) else $error("clear failed"); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    swt_expire |=> reg_rdata[7]) else $error("set lost"); // R11

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !(reg_wr && reg_wdata[7])) |=> reg_rdata[7]) else $error("sticky bit dropped"); // R12
endmodule

bind smi_status_agg smi_status_agg_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .ecc_irq       (ecc_irq),
  .ecc_serr_en   (ecc_serr_en),
  .swt_expire    (swt_expire),
  .minute_expire (minute_expire),
  .reg_wr        (reg_wr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .pwr_state     (pwr_state),
  .ext_evt_en    (ext_evt_en),
  .smi_req       (smi_req),
  .wake_req      (wake_req)
);

// File: tb/test_smi_status_agg.sv
`timescale 1ns/1ps
module test_smi_status_agg;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct {
    logic [15:0] rd;
    logic        smi;
    logic        wake;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ecc_irq, ecc_serr_en, ecc_smi_en, fw_wr_en_cfg;
  logic [7:0]  gpio_lvl, gpio_smi_route;
  logic        ext_evt_en;
  logic [2:0]  pwr_state;
  logic        swt_expire, minute_expire, pmc_wr, pmc_en, rel_req_wr, fw_rel_en;
  logic [7:0]  gp_sts_vec, pm1_sts_vec;
  logic [3:0]  usb_sts, usb_en;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        smi_req, wake_req;

  // reference model state
  logic [15:0] m_sts;
  logic        m_ecc_prev;
  logic        m_fw_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_status_agg i_smi_status_agg (
    .clk(clk), .rst_n(rst_n), .ecc_irq(ecc_irq), .ecc_serr_en(ecc_serr_en),
    .ecc_smi_en(ecc_smi_en), .fw_wr_en_cfg(fw_wr_en_cfg), .gpio_lvl(gpio_lvl),
    .gpio_smi_route(gpio_smi_route), .ext_evt_en(ext_evt_en), .pwr_state(pwr_state),
    .swt_expire(swt_expire), .minute_expire(minute_expire), .pmc_wr(pmc_wr),
    .pmc_en(pmc_en), .rel_req_wr(rel_req_wr), .fw_rel_en(fw_rel_en),
    .gp_sts_vec(gp_sts_vec), .pm1_sts_vec(pm1_sts_vec), .usb_sts(usb_sts),
    .usb_en(usb_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smi_req(smi_req), .wake_req(wake_req)
  );

  // driver: model the coming edge, push the expectation, move to next falling edge
  task automatic tick(input string tag);
    logic [15:0] setv;
    logic [15:0] live;
    exp_t        e;
    setv     = '0;
    setv[10] = ecc_irq && (!ecc_serr_en || m_ecc_prev);
    setv[9]  = fw_wr_en_cfg && !m_fw_prev;
    setv[8]  = |(gpio_lvl & gpio_smi_route);
    setv[7]  = swt_expire;
    setv[6]  = minute_expire;
    setv[3]  = pmc_wr;
    setv[0]  = rel_req_wr && fw_rel_en;
    m_ecc_prev = ecc_irq;
    m_fw_prev  = fw_wr_en_cfg;
    foreach (setv[b]) begin
      if (16'h07C9 & (16'h1 << b))
        m_sts[b] = setv[b] | (m_sts[b] & !(reg_wr && reg_wdata[b]));
    end
    live    = '0;
    live[5] = |gp_sts_vec;
    live[4] = |pm1_sts_vec;
    live[1] = |(usb_sts & usb_en);
    e.rd   = m_sts | live;
    e.smi  = (m_sts[10] && ecc_smi_en) || m_sts[9] || m_sts[6] || m_sts[0] ||
             (m_sts[3] && pmc_en) || (m_sts[8] && ext_evt_en && pwr_state <= 3'd3);
    e.wake = m_sts[8] && ext_evt_en && (pwr_state >= 3'd3) && (pwr_state <= 3'd6);
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic w1c(input logic [15:0] mask, input string tag);
    reg_wr = 1'b1;
    reg_wdata = mask;
    tick(tag);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (reg_rdata !== e.rd || smi_req !== e.smi || wake_req !== e.wake) begin
          n_fail++;
          $display("FAIL %s: rdata=%h smi=%b wake=%b expected rdata=%h smi=%b wake=%b",
                   e.tag, reg_rdata, smi_req, wake_req, e.rd, e.smi, e.wake);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {ecc_irq, ecc_serr_en, ecc_smi_en, fw_wr_en_cfg, ext_evt_en} = '0;
    {swt_expire, minute_expire, pmc_wr, pmc_en, rel_req_wr, fw_rel_en} = '0;
    gpio_lvl = '0; gpio_smi_route = '0; pwr_state = '0;
    gp_sts_vec = '0; pm1_sts_vec = '0; usb_sts = '0; usb_en = '0;
    reg_wr = 1'b0; reg_wdata = '0;
    m_sts = '0; m_ecc_prev = 1'b0; m_fw_prev = 1'b0;

    repeat (3) @(negedge clk);
    n_chk++;
    if (reg_rdata !== 16'h0 || smi_req !== 1'b0 || wake_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: rdata=%h smi=%b wake=%b expected rdata=0000 smi=0 wake=0",
               reg_rdata, smi_req, wake_req);
    end
    rst_n = 1'b1;
    repeat (3) tick("R1");

    // R1 / R10: clearing write on an empty word, reserved bits stay zero
    w1c(16'hFFFF, "R1");

    // R2 / R4: unqualified ECC, SMI gated by its enable
    ecc_irq = 1'b1; tick("R2"); ecc_irq = 1'b0;
    tick("R4");
    ecc_smi_en = 1'b1; tick("R4");
    w1c(16'h0400, "R10");

    // R3: qualified ECC needs two consecutive clocks
    ecc_serr_en = 1'b1;
    ecc_irq = 1'b1; tick("R3"); ecc_irq = 1'b0; tick("R3");
    ecc_irq = 1'b1; tick("R3"); tick("R3"); ecc_irq = 1'b0; tick("R3");
    w1c(16'h0400, "R10");
    ecc_serr_en = 1'b0;

    // R5: rising edge only, SMI always
    fw_wr_en_cfg = 1'b1; tick("R5");
    w1c(16'h0200, "R5");
    tick("R5");
    fw_wr_en_cfg = 1'b0; tick("R5");

    // R6: routing across all power state codes
    ext_evt_en = 1'b1; gpio_smi_route = 8'h04;
    gpio_lvl = 8'h02; tick("R6"); gpio_lvl = 8'h00;
    for (int s = 0; s < 8; s++) begin
      pwr_state = 3'(s);
      gpio_lvl = 8'h04; tick("R6"); gpio_lvl = 8'h00;
      tick("R6");
      w1c(16'h0100, "R6");
    end
    pwr_state = 3'd3;
    gpio_lvl = 8'h04; tick("R6"); gpio_lvl = 8'h00;
    ext_evt_en = 1'b0; tick("R6");
    w1c(16'h0100, "R6");
    pwr_state = 3'd0;

    // R7: timer expiries
    swt_expire = 1'b1; tick("R7"); swt_expire = 1'b0;
    minute_expire = 1'b1; tick("R7"); minute_expire = 1'b0;
    w1c(16'h00C0, "R7");

    // R8: live summary bits, writes ignored
    gp_sts_vec = 8'h10; tick("R8");
    pm1_sts_vec = 8'h01; tick("R8");
    usb_sts = 4'b0101; usb_en = 4'b1010; tick("R8");
    usb_en = 4'b0100; tick("R8");
    w1c(16'h0032, "R8");
    gp_sts_vec = '0; pm1_sts_vec = '0; usb_sts = '0; usb_en = '0; tick("R8");

    // R9: control port write and firmware release
    pmc_wr = 1'b1; tick("R9"); pmc_wr = 1'b0;
    pmc_en = 1'b1; tick("R9");
    w1c(16'h0008, "R9");
    rel_req_wr = 1'b1; tick("R9"); rel_req_wr = 1'b0;
    fw_rel_en = 1'b1;
    rel_req_wr = 1'b1; tick("R9"); rel_req_wr = 1'b0;

    // R10: zero data does not clear
    w1c(16'h0000, "R10");
    w1c(16'h0001, "R10");

    // R11: set wins over clear
    swt_expire = 1'b1; w1c(16'h0080, "R11"); swt_expire = 1'b0;
    tick("R11");
    w1c(16'h0080, "R11");

    // R12: level outputs hold
    minute_expire = 1'b1; tick("R12"); minute_expire = 1'b0;
    repeat (5) tick("R12");
    ext_evt_en = 1'b1; pwr_state = 3'd5;
    gpio_lvl = 8'h04; tick("R12"); gpio_lvl = 8'h00;
    repeat (4) tick("R12");
    w1c(16'h0140, "R12");

    while (sb.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule